// File: doc/BRIEF.md
# Page write load controller

This block is the write side of a byte-alterable nonvolatile memory model with a 13-bit byte address and an 8-bit data path. A host presents single-cycle write strobes. The first strobe accepted while the block is idle opens a page and fixes its page number. Up to 64 bytes of that page are then collected into a page buffer. Each further byte must arrive within a programmable number of clock cycles of the previous accepted byte. There is no limit on how long a page load may last, provided every byte arrives inside its window.

When the window runs out with no new byte, the block enters a self-timed programming cycle and raises `busy`. During the first 64 cycles of that period it scans the buffer in ascending offset order. It presents only the bytes that were actually loaded on a commit port to the storage array. No erase pass comes before the commit, so array locations that were not loaded keep their old contents. `busy` drops after a fixed programming time, and the block is then ready for a new page.

The byte-load window and the programming time are parameters counted in clock cycles. Real-time values can therefore be mapped onto any clock, and a bench can shorten them.

Top module: `pgwr_ctrl`

## Requirements
- R1: After a synchronous reset, `busy`, `commit_valid` and `page_err` are low and the block is idle, so the next strobe opens a page.
- R2: A strobe accepted while idle opens a page. The page number is address bits 12..6 and the byte offset within the page is bits 5..0. Every commit of that page carries this page number in `commit_addr[12:6]`.
- R3: A further strobe to the locked page is accepted if it falls no more than WIN_CYC clock edges after the previous accepted strobe. Each accepted strobe restarts the window, and there is no limit on the total load time.
- R4: When WIN_CYC clock edges pass after the last accepted strobe with no new accepted strobe, `busy` is high from the following cycle on and not before.
- R5: A strobe in an open page whose page number differs from the locked one is dropped. It sets `page_err`, which stays high until reset, and it does not restart the byte-load window.
- R6: `busy` stays high for exactly PROG_CYC consecutive cycles and then falls.
- R7: While `busy` is high, each loaded offset is presented once on the commit port with `commit_valid` high, in ascending offset order, with `commit_addr` = {page, offset}. Offsets that were not loaded are never presented, so their array contents are untouched.
- R8: When one offset is loaded more than once in a page, only the last value is committed, and it is committed once.
- R9: Strobes that arrive while `busy` is high are dropped. They raise no error, store no data and do not open a new page after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle host write strobe |
| wr_addr | input | 13 | Host byte address |
| wr_data | input | 8 | Host write data |
| busy | output | 1 | Programming cycle in progress |
| page_err | output | 1 | Sticky flag: a load to a foreign page was dropped |
| commit_valid | output | 1 | Commit port carries a byte for the array |
| commit_addr | output | 13 | Array address of the committed byte |
| commit_data | output | 8 | Committed byte |

## Verification
The hardest cases to reach from the ports lie on the exact edge of the byte-load window. The first is a strobe landing on the last permitted edge, which must still be accepted. The second is a foreign-page strobe just before expiry, which must not extend the window. The stimulus counts falling edges from each accepted strobe so that it places a strobe on edge WIN_CYC, and separately on edge WIN_CYC-1. It then samples `busy` one cycle before and in the cycle of the expected rise. A strobe is also issued in the middle of programming, and the port is then watched for a full window after `busy` falls, to show that no page was opened.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    localparam int ADDR_W     = 13;
    localparam int DATA_W     = 8;
    localparam int OFF_W      = 6;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int PAGE_W     = ADDR_W - OFF_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } state_e;

    typedef struct packed {
        page_t page;
        off_t  off;
        byte_t data;
    } load_t;

    function automatic page_t page_of(input addr_t a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    function automatic off_t off_of(input addr_t a);
        return a[OFF_W-1:0];
    endfunction

endpackage

// File: rtl/pgwr_counter.sv
module pgwr_counter #(
    parameter int MAX = 16,
    localparam int CW = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          en,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pgwr_buffer.sv
module pgwr_buffer
    import pgwr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  wr,
    input  off_t  wr_off,
    input  byte_t wr_data,
    input  off_t  rd_off,
    output byte_t rd_data,
    output logic  rd_loaded
);

    logic [PAGE_BYTES-1:0] vld_vec;
    byte_t                 dat_arr [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic  vld;
        byte_t dat;
        logic  hit;

        assign hit = wr && (wr_off == off_t'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld <= 1'b0;
                dat <= '0;
            end else if (hit) begin
                vld <= 1'b1;
                dat <= wr_data;
            end else if (clr) begin
                vld <= 1'b0;
            end
        end

        assign vld_vec[g] = vld;
        assign dat_arr[g] = dat;
    end

    assign rd_data   = dat_arr[rd_off];
    assign rd_loaded = vld_vec[rd_off];

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int WIN_CYC  = 5000,
    parameter int PROG_CYC = 250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              page_err,
    output logic              commit_valid,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data
);

    localparam int WCW = $clog2(WIN_CYC + 1);
    localparam int PCW = $clog2(PROG_CYC + 1);
    localparam logic [WCW-1:0] WIN_LAST  = WCW'(WIN_CYC - 1);
    localparam logic [PCW-1:0] PROG_LAST = PCW'(PROG_CYC - 1);
    localparam logic [PCW-1:0] SCAN_END  = PCW'(PAGE_BYTES);

    state_e         state_q;
    page_t          page_q;
    logic           err_q;
    load_t          ld;
    logic           take_first, take_more, foreign, take;
    logic [WCW-1:0] win_cnt;
    logic [PCW-1:0] prog_cnt;
    logic           win_done, prog_done, scanning;
    byte_t          rd_data;
    logic           rd_loaded;

    assign ld = '{page: page_of(wr_addr), off: off_of(wr_addr), data: wr_data};

    assign take_first = (state_q == ST_IDLE) && wr_en;
    assign take_more  = (state_q == ST_LOAD) && wr_en && (ld.page == page_q);
    assign foreign    = (state_q == ST_LOAD) && wr_en && (ld.page != page_q);
    assign take       = take_first || take_more;

    pgwr_counter #(.MAX(WIN_CYC)) u_win (
        .clk   (clk),
        .rst   (rst),
        .clear (take),
        .en    (state_q == ST_LOAD),
        .cnt   (win_cnt)
    );

    pgwr_counter #(.MAX(PROG_CYC)) u_prog (
        .clk   (clk),
        .rst   (rst),
        .clear (state_q != ST_PROG),
        .en    (state_q == ST_PROG),
        .cnt   (prog_cnt)
    );

    assign win_done  = (win_cnt == WIN_LAST);
    assign prog_done = (prog_cnt == PROG_LAST);
    assign scanning  = (state_q == ST_PROG) && (prog_cnt < SCAN_END);

    pgwr_buffer u_buf (
        .clk       (clk),
        .rst       (rst),
        .clr       (take_first),
        .wr        (take),
        .wr_off    (ld.off),
        .wr_data   (ld.data),
        .rd_off    (prog_cnt[OFF_W-1:0]),
        .rd_data   (rd_data),
        .rd_loaded (rd_loaded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            page_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            if (foreign) begin
                err_q <= 1'b1;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (take_first) begin
                        page_q  <= ld.page;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (!take_more && win_done) begin
                        state_q <= ST_PROG;
                    end
                end
                ST_PROG: begin
                    if (prog_done) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (state_q == ST_PROG);
    assign page_err     = err_q;
    assign commit_valid = scanning && rd_loaded;
    assign commit_addr  = {page_q, prog_cnt[OFF_W-1:0]};
    assign commit_data  = rd_data;

endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk
    import pgwr_pkg::*;
#(
    parameter int PROG_CYC = 250000
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              busy,
    input logic              page_err,
    input logic              commit_valid,
    input logic [ADDR_W-1:0] commit_addr
);

    localparam int BCW = $clog2(PROG_CYC + 2);

    logic [BCW-1:0] bcnt;
    logic           prev_busy;
    logic           seen;
    off_t           last_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt      <= '0;
            prev_busy <= 1'b0;
        end else begin
            prev_busy <= busy;
            if (busy) begin
                bcnt <= prev_busy ? bcnt + 1'b1 : BCW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            seen     <= 1'b0;
            last_off <= '0;
        end else if (commit_valid) begin
            seen     <= 1'b1;
            last_off <= commit_addr[OFF_W-1:0];
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!busy && !commit_valid && !page_err));

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        page_err |=> page_err);

    p_busy_len_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (bcnt == BCW'(PROG_CYC)));

    p_commit_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
        commit_valid |-> busy);

    p_commit_ascend_r7: assert property (@(posedge clk) disable iff (rst)
        (commit_valid && seen) |-> (commit_addr[OFF_W-1:0] > last_off));

    p_page_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(commit_addr[ADDR_W-1:OFF_W]));

    p_busy_noerr_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && !page_err) |=> !page_err);

endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(.PROG_CYC(PROG_CYC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .busy         (busy),
    .page_err     (page_err),
    .commit_valid (commit_valid),
    .commit_addr  (commit_addr)
);

// File: tb/tb_pgwr_ctrl.sv
module tb_pgwr_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 8;
    localparam int PROG       = 80;
    localparam int NVEC       = 8;

    // {end-of-page nibble, 0, addr[15:0], data[7:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        32'h0001_40AA,
        32'h0001_4155,
        32'h0001_7F3C,
        32'h1001_4011,
        32'h001F_C001,
        32'h000A_8077,
        32'h101F_C522,
        32'h1000_00FF
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy, page_err, commit_valid;
    logic [12:0] commit_addr;
    logic [7:0]  commit_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0]  exp_data [64];
    logic [63:0] exp_mask;
    logic [6:0]  exp_page;
    logic        exp_err;
    bit          page_open;

    logic [7:0]  got_data [64];
    logic [63:0] got_mask;
    logic [6:0]  got_page;
    int          got_n;
    int          bcnt;
    bit          order_bad;
    bit          have_last;
    logic [5:0]  last_off;
    bit          clr_got = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgwr_ctrl #(.WIN_CYC(WIN), .PROG_CYC(PROG)) dut (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .busy         (busy),
        .page_err     (page_err),
        .commit_valid (commit_valid),
        .commit_addr  (commit_addr),
        .commit_data  (commit_data)
    );

    always @(negedge clk) begin
        if (clr_got) begin
            got_mask  <= '0;
            got_n     <= 0;
            bcnt      <= 0;
            order_bad <= 1'b0;
            have_last <= 1'b0;
        end else begin
            if (busy) bcnt <= bcnt + 1;
            if (commit_valid) begin
                got_data[commit_addr[5:0]] <= commit_data;
                got_mask[commit_addr[5:0]] <= 1'b1;
                got_page  <= commit_addr[12:6];
                got_n     <= got_n + 1;
                if (have_last && commit_addr[5:0] <= last_off) order_bad <= 1'b1;
                last_off  <= commit_addr[5:0];
                have_last <= 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic clear_got();
        @(posedge clk);
        clr_got = 1'b1;
        @(posedge clk);
        clr_got = 1'b0;
        @(negedge clk);
    endtask

    task automatic open_page(input logic [12:0] a);
        exp_mask  = '0;
        exp_page  = a[12:6];
        page_open = 1'b1;
    endtask

    task automatic model_load(input logic [12:0] a, input logic [7:0] d);
        if (a[12:6] == exp_page) begin
            exp_data[a[5:0]] = d;
            exp_mask[a[5:0]] = 1'b1;
        end else begin
            exp_err = 1'b1;
        end
    endtask

    task automatic finish_page();
        int pop;
        bit data_ok;
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
        pop = $countones(exp_mask);
        data_ok = 1'b1;
        for (int i = 0; i < 64; i++) begin
            if (exp_mask[i] && got_data[i] !== exp_data[i]) data_ok = 1'b0;
        end
        chk(bcnt == PROG, "R6", "busy length", bcnt, PROG);
        chk(got_mask === exp_mask, "R7", "committed offsets", got_mask, exp_mask);
        chk(order_bad == 1'b0, "R7", "ascending order", order_bad, 0);
        chk(data_ok, "R8", "committed data", data_ok, 1);
        chk(got_n == pop, "R8", "commit count", got_n, pop);
        chk(got_page == exp_page, "R2", "commit page", got_page, exp_page);
        chk(page_err == exp_err, "R5", "page_err", page_err, exp_err);
        page_open = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        exp_err   = 1'b0;
        page_open = 1'b0;
        exp_mask  = '0;
        exp_page  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(commit_valid == 1'b0, "R1", "commit_valid after reset", commit_valid, 0);
        chk(page_err == 1'b0, "R1", "page_err after reset", page_err, 0);

        // Table walk: R2, R5, R7, R8
        for (int v = 0; v < NVEC; v++) begin
            if (!page_open) begin
                clear_got();
                open_page(VEC[v][20:8]);
            end
            model_load(VEC[v][20:8], VEC[v][7:0]);
            do_write(VEC[v][20:8], VEC[v][7:0]);
            if (VEC[v][28]) finish_page();
        end

        // R1: reset clears the sticky error
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        exp_err = 1'b0;
        chk(page_err == 1'b0, "R1", "page_err cleared by reset", page_err, 0);

        // R3 / R4 / R9: strobe on the last window edge, then expiry
        clear_got();
        open_page(13'h0400);
        model_load(13'h0400, 8'hA1);
        do_write(13'h0400, 8'hA1);
        repeat (WIN - 1) @(negedge clk);
        model_load(13'h0403, 8'hB2);
        do_write(13'h0403, 8'hB2);
        chk(busy == 1'b0, "R3", "load on last window edge kept page open", busy, 0);
        repeat (WIN - 1) @(negedge clk);
        chk(busy == 1'b0, "R4", "busy one cycle before expiry", busy, 0);
        @(negedge clk);
        chk(busy == 1'b1, "R4", "busy at expiry", busy, 1);
        do_write(13'h1000, 8'hCC);
        repeat (3) @(negedge clk);
        chk(page_err == 1'b0, "R9", "no error for strobe while busy", page_err, 0);
        finish_page();
        repeat (WIN + 4) @(negedge clk);
        chk(busy == 1'b0, "R9", "no page opened by strobe during busy", busy, 0);

        // R5: foreign strobe must not extend the window
        clear_got();
        open_page(13'h0800);
        model_load(13'h0800, 8'h5A);
        do_write(13'h0800, 8'h5A);
        repeat (WIN - 2) @(negedge clk);
        model_load(13'h0040, 8'h99);
        do_write(13'h0040, 8'h99);
        chk(busy == 1'b0, "R5", "busy before expiry", busy, 0);
        @(negedge clk);
        chk(busy == 1'b1, "R5", "window not restarted by foreign strobe", busy, 1);
        chk(page_err == 1'b1, "R5", "page_err set", page_err, 1);
        finish_page();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule